// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides the output of an external dual-modulus prescaler in the feedback path of an integer-N synthesizer. It counts prescaler output pulses, which arrive as a one-cycle strobe on `tick_i`, with two down counters. The swallow counter (A) and the main counter (B) both start each frame loaded from configuration. While A is still nonzero, the block asks the prescaler to divide by P+1. Once A is exhausted, it asks for division by P. When B reaches its last count, the block emits one output strobe and both counters reload. The frame therefore spans N = P·B + A input cycles. The prescaler-select bit travels with A and B, so the modulus the prescaler uses always matches the frame being counted.

A power-down or counter-reset controller can hold the divider in its load state through `hold_i`. While held, the counters follow the configuration and no strobe is produced. After `hold_i` is released, the divider stays in the load state until the reference divider sends `start_i`. Counting then begins on the next prescaler pulse, so the two dividers start on the same reference edge. The remaining misalignment is at most one prescaler output period.

Top module: `nd_pulse_swallow_div`

## Requirements
- R1: While `rst_ni` is low, `mod_o`, `pulse_o` and `pre_sel_o` are 0.
- R2: `mod_o` is 1 (divide by P+1) for the first A prescaler pulses of each frame and 0 for the remaining B−A pulses. With A = 0 it stays 0 for the whole frame.
- R3: `pulse_o` is a one-cycle strobe in the cycle of the B-th counted `tick_i` of a frame. With a prescaler that obeys `mod_o` and `pre_sel_o`, the distance between two strobes is P·B + A input cycles, where P is the low modulus when `pre_sel_o` = 0 and the high modulus when it is 1.
- R4: While `hold_i` is 1, `pulse_o` is 0 and both counters are reloaded from configuration. After `hold_i` falls, no strobe appears until `start_i` has been seen.
- R5: After `start_i` (with `hold_i` low), the first `pulse_o` comes with the B-th `tick_i` after the start cycle.
- R6: A, B and the prescaler-select bit are taken only in the load state or at a frame end. A change in the middle of a frame affects neither the current frame nor `pre_sel_o` until that frame's strobe.
- R7: `cfg_err_o` is 1 exactly when the configured B is 0 or smaller than the configured A.
- R8: A `tick_i` that arrives in the load state does not advance the counters and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per prescaler output pulse |
| hold_i | input | 1 | Counter reset / power-down: force load state |
| start_i | input | 1 | Start strobe from the reference divider |
| pre_sel_i | input | 1 | Prescaler modulus select (0 low pair, 1 high pair) |
| a_cfg_i | input | A_W | Swallow count A |
| b_cfg_i | input | B_W | Main count B |
| mod_o | output | 1 | Modulus control: 1 requests P+1, 0 requests P |
| pre_sel_o | output | 1 | Prescaler select latched for the current frame |
| pulse_o | output | 1 | Divided output strobe, one per frame |
| cfg_err_o | output | 1 | Configuration error (B = 0 or B < A) |

## Verification
The hardest cases to reach are a configuration change in the middle of a frame and a start that lands inside a prescaler period already in progress. Only a prescaler that follows the block's own `mod_o` can reach them. The bench therefore closes the loop with a behavioural prescaler, which sets each period length from `mod_o` and `pre_sel_o` right after the previous pulse. It rewrites A, B and the select bit while frames are running and measures every strobe-to-strobe distance against P·B + A of the frame that was latched. It also applies hold in the middle of a frame, and it restarts with start strobes that are not related to the prescaler phase.

// File: rtl/nd_pkg.sv
package nd_pkg;
  localparam int unsigned A_W_DEF = 6;
  localparam int unsigned B_W_DEF = 11;
  typedef enum logic {PS_LOW = 1'b0, PS_HIGH = 1'b1} ps_sel_e;
endpackage

// File: rtl/nd_down_ctr.sv
module nd_down_ctr #(
  parameter int unsigned W = 6,
  parameter bit HOLD_AT_ZERO = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o,
  output logic         one_o
);
  logic [W-1:0] cnt_q;
  logic         dec;

  generate
    if (HOLD_AT_ZERO) begin : g_sat
      assign dec = step_i && (cnt_q != '0);
    end else begin : g_wrap
      assign dec = step_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec)    cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign one_o  = (cnt_q == W'(1));

  // R6
  ctr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(val_i));
  // R2
  ctr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R8
  ctr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(cnt_q));
endmodule

// File: rtl/nd_cfg_check.sv
module nd_cfg_check #(
  parameter int unsigned A_W = 6,
  parameter int unsigned B_W = 11
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic           err_o
);
  localparam int unsigned CW = (A_W > B_W) ? A_W : B_W;
  logic [CW-1:0] a_ext, b_ext;

  always_comb begin
    a_ext = CW'(a_i);
    b_ext = CW'(b_i);
    err_o = (b_ext == '0) || (b_ext < a_ext);
  end
endmodule

// File: rtl/nd_pulse_swallow_div.sv
module nd_pulse_swallow_div #(
  parameter int unsigned A_W = nd_pkg::A_W_DEF,
  parameter int unsigned B_W = nd_pkg::B_W_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           hold_i,
  input  logic           start_i,
  input  logic           pre_sel_i,
  input  logic [A_W-1:0] a_cfg_i,
  input  logic [B_W-1:0] b_cfg_i,
  output logic           mod_o,
  output logic           pre_sel_o,
  output logic           pulse_o,
  output logic           cfg_err_o
);
  import nd_pkg::*;

  logic           run_q;
  ps_sel_e        sel_q;
  logic           step, frame_end, ld;
  logic [A_W-1:0] a_cnt;
  logic [B_W-1:0] b_cnt;
  logic           a_zero, a_one, b_zero, b_one;

  assign step      = run_q && tick_i && !hold_i;
  assign frame_end = step && b_one;
  assign ld        = hold_i || !run_q || frame_end;

  nd_down_ctr #(.W(A_W), .HOLD_AT_ZERO(1'b1)) u_a_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld), .step_i(step),
    .val_i(a_cfg_i), .cnt_o(a_cnt), .zero_o(a_zero), .one_o(a_one)
  );

  nd_down_ctr #(.W(B_W), .HOLD_AT_ZERO(1'b0)) u_b_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld), .step_i(step),
    .val_i(b_cfg_i), .cnt_o(b_cnt), .zero_o(b_zero), .one_o(b_one)
  );

  nd_cfg_check #(.A_W(A_W), .B_W(B_W)) u_cfg_check (
    .a_i(a_cfg_i), .b_i(b_cfg_i), .err_o(cfg_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= 1'b0;
    else if (hold_i)   run_q <= 1'b0;
    else if (start_i)  run_q <= 1'b1;
  end

  // select travels with the frame it belongs to
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  sel_q <= PS_LOW;
    else if (ld)  sel_q <= ps_sel_e'(pre_sel_i);
  end

  assign mod_o     = !a_zero;
  assign pre_sel_o = sel_q;
  assign pulse_o   = frame_end;

  // R4
  hold_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !pulse_o);
  // R4
  hold_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !run_q);
  // R3
  pulse_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> b_cnt == $past(b_cfg_i));
  // R6
  sel_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> $stable(pre_sel_o));
  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !pulse_o);
  // R2
  swallow_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !frame_end && a_one) |=> !mod_o);

  logic unused_ok;
  assign unused_ok = b_zero;
endmodule

// File: tb/sim_nd_pulse_swallow_div.sv
module sim_nd_pulse_swallow_div;
  localparam int A_W  = 6;
  localparam int B_W  = 11;
  localparam int P_LO = 8;
  localparam int P_HI = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, hold = 1'b0, start = 1'b0, pre_sel = 1'b0;
  logic [A_W-1:0] a_cfg = '0;
  logic [B_W-1:0] b_cfg = '0;
  logic mod_o, pre_sel_o, pulse_o, cfg_err_o;

  nd_pulse_swallow_div #(.A_W(A_W), .B_W(B_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .hold_i(hold), .start_i(start),
    .pre_sel_i(pre_sel), .a_cfg_i(a_cfg), .b_cfg_i(b_cfg),
    .mod_o(mod_o), .pre_sel_o(pre_sel_o), .pulse_o(pulse_o), .cfg_err_o(cfg_err_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  // stimulus requests, applied at the next negedge
  bit s_rst = 0, s_hold = 0, s_start = 0, s_sel = 0;
  int s_a = 0, s_b = 0;
  // prescaler model
  int prem = P_LO;
  // reference model
  bit m_run = 0, m_sel = 0;
  int m_a = 0, m_b = 0, m_idx = 0;
  int cyc = 0, plast = 0, ticks_ss = 0;
  bit pvalid = 0, fresh = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit fe, adv, p_exp, m_exp, e_exp;
    int per;
    @(negedge clk);
    rst_n = s_rst; hold = s_hold; start = s_start; pre_sel = s_sel;
    a_cfg = A_W'(s_a); b_cfg = B_W'(s_b);
    if (tick) begin
      prem = (pre_sel_o ? P_HI : P_LO) + (mod_o ? 1 : 0);
      tick = 0;
    end
    prem--;
    if (prem <= 0) tick = 1;
    #1;
    if (!rst_n) begin
      chk(mod_o == 0 && pulse_o == 0 && pre_sel_o == 0, "R1 reset outputs",
          {mod_o, pulse_o, pre_sel_o}, 0);
      m_run = 0; m_sel = 0; m_a = 0; m_b = 0; m_idx = 0; pvalid = 0; fresh = 0;
    end else begin
      fe    = m_run && tick && !hold && (m_idx == m_b - 1);
      adv   = m_run && tick && !hold;
      p_exp = fe;
      m_exp = (m_idx < m_a);
      e_exp = (s_b == 0) || (s_b < s_a);
      chk(mod_o == m_exp, "R2 mod", mod_o, m_exp);
      if (hold)        chk(pulse_o == p_exp, "R4 pulse during hold", pulse_o, p_exp);
      else if (!m_run) chk(pulse_o == p_exp, "R8 pulse in load state", pulse_o, p_exp);
      else             chk(pulse_o == p_exp, "R3 pulse", pulse_o, p_exp);
      chk(pre_sel_o == m_sel, "R6 latched select", pre_sel_o, m_sel);
      chk(cfg_err_o == e_exp, "R7 cfg error", cfg_err_o, e_exp);
      if (adv) ticks_ss++;
      if (p_exp) begin
        if (pvalid) begin
          per = (m_sel ? P_HI : P_LO) * m_b + m_a;
          chk(cyc - plast == per, "R3 period", cyc - plast, per);
        end
        if (fresh) chk(ticks_ss == m_b, "R5 ticks to first pulse", ticks_ss, m_b);
        fresh = 0; pvalid = 1; plast = cyc;
      end
      if (hold || !m_run) pvalid = 0;
      if (hold || !m_run || fe) begin
        m_a = s_a; m_b = s_b; m_sel = s_sel; m_idx = 0;
      end else if (adv) m_idx++;
      if (hold) m_run = 0;
      else if (start && !m_run) begin m_run = 1; fresh = 1; ticks_ss = 0; end
    end
    cyc++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic kick();
    s_start = 1; step(); s_start = 0;
  endtask

  initial begin
    run(4);
    s_a = 3; s_b = 5; s_sel = 0; s_rst = 1;
    run(30);                     // R8: ticks while idle
    kick();
    run(300);                    // R3 P=8 A=3 B=5
    s_a = 0; s_b = 4; run(300);  // R2 A=0, R6 mid-frame change
    s_sel = 1; s_a = 2; s_b = 3; run(400);
    s_sel = 0; s_a = 6; s_b = 6; run(300);
    s_hold = 1; run(40);         // R4
    s_hold = 0; run(60);
    s_a = 5; s_b = 9; run(7);
    kick(); run(400);            // R5 unaligned start
    s_a = 9; s_b = 5; run(3);    // R7 B<A
    s_b = 0; run(3);             // R7 B=0
    s_hold = 1; s_a = 1; s_b = 2; run(5);
    s_hold = 0; kick(); run(200);
    s_rst = 0; run(3);           // R1 reset mid-run
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule